// File: doc/BRIEF.md
# Prescaled Interval Counter with Coherent Byte Read

This block is a 16-bit up-counter that runs freely. It advances on enable pulses taken from a 6-bit power-of-two prescaler clocked by the bus clock. A 3-bit select field chooses one of seven prescaler taps, giving a divide ratio from 1 to 64. When the counter wraps, it sets a sticky overflow flag. That flag raises an interrupt output if the interrupt enable bit is set.

Software reaches the block through a byte-wide register port with single-cycle read and write strobes. The read data is valid during the strobe cycle. The counter is split into a high byte and a low byte. Reading the high byte freezes a copy of the low byte, so two 8-bit reads give one consistent 16-bit value. Software can restart counting from zero by writing a self-clearing bit in the control register.

Register addresses: 0 is control, 1 is the counter high byte, 2 is the counter low byte, and 3 always reads 0. Control register fields:

- bits [2:0]: tap select
- bit 3: overflow flag (write 1 to clear)
- bit 4: interrupt enable
- bit 5: counter clear (write-only, reads 0)
- bits [7:6]: read as 0

Top module: `prescaled_timer`

## Requirements
- R1: After reset, control reads 0x00, both counter bytes read 0x00, and irq is low.
- R2: Select codes 0 to 6 advance the counter once every 2^code bus clocks. With code 0 it advances on every clock.
- R3: Select code 7 advances the counter at the same rate as code 6, which is once every 64 clocks.
- R4: A read at address 1 returns the live high byte and copies the low byte into a buffer. A following read at address 2 returns the buffered byte and releases the buffer.
- R5: While the buffer is held, further reads at address 1 leave the buffered byte unchanged.
- R6: A read at address 2 with no buffer held returns the live low byte.
- R7: Writes to addresses 1, 2 and 3 change neither the counter nor the buffer.
- R8: Writing 1 to control bit 5 sets the counter and the prescaler to zero. The first count after that takes a full tap period. Bit 5 always reads 0.
- R9: A wrap from 0xFFFF to 0x0000 sets control bit 3. The flag stays set until 1 is written to bit 3. irq equals bit 3 AND bit 4.
- R10: If address 2 is never read after a read at address 1, the buffered byte stays the same for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register, valid while rdEn is high |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong prescaler phase or a wrong tap decode shows up as a counter value that drifts from the expected count. This appears within one tap period, at most 64 clocks, on the next read of either byte. A buffer that is overwritten or released early shows up as a mismatch on the very next low-byte read. That read is placed after long idle gaps and after repeated high-byte reads. A flag that is lost or cleared wrongly shows up on irq in the cycle after the wrap or the clearing write, and in control bit 3 when control is next read.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef struct packed {
    logic clearCnt;
    logic latchLow;
    logic releaseLow;
  } ctrlStrobes_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_LOW  = 2'd2;

  localparam int BIT_FLAG  = 3;
  localparam int BIT_IEN   = 4;
  localparam int BIT_CLEAR = 5;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 6,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [SEL_W-1:0]  tapSel,
  output logic [CNT_W-1:0]  cntQ,
  output logic [DATA_W-1:0] bufQ,
  output logic              latchedQ,
  output logic              wrapPulse
);
  localparam int TAPS = DIV_W + 1;

  logic [DIV_W-1:0] divQ;
  logic [TAPS-1:0]  tapTick;
  logic             tick;
  logic [SEL_W-1:0] effSel;

  assign tapTick[0] = 1'b1;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tapTick[k] = &divQ[k-1:0];
  end

  always_comb begin
    if (int'(tapSel) > DIV_W) effSel = SEL_W'(DIV_W);
    else                      effSel = tapSel;
  end

  assign tick      = tapTick[effSel];
  assign wrapPulse = tick && !strobes.clearCnt && (cntQ == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
      cntQ <= '0;
    end else if (strobes.clearCnt) begin
      divQ <= '0;
      cntQ <= '0;
    end else begin
      divQ <= divQ + 1'b1;
      if (tick) cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedQ <= 1'b0;
      bufQ     <= '0;
    end else if (strobes.releaseLow) begin
      latchedQ <= 1'b0;
    end else if (strobes.latchLow && !latchedQ) begin
      latchedQ <= 1'b1;
      bufQ     <= cntQ[DATA_W-1:0];
    end
  end

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCnt |=> (cntQ == '0));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearCnt |=> (cntQ == $past(cntQ)) || (cntQ == CNT_W'($past(cntQ) + 1'b1)));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchedQ && !strobes.releaseLow) |=> ($stable(bufQ) && latchedQ));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.releaseLow |=> !latchedQ);
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic [DATA_W-1:0] bufQ,
  input  logic              latchedQ,
  input  logic              wrapPulse,
  output ctrlStrobes_t      strobes,
  output logic [SEL_W-1:0]  tapSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic flagQ;
  logic ienQ;
  logic ctrlWr;

  assign ctrlWr = wrEn && (addr == ADDR_CTRL);

  always_comb begin
    strobes            = '0;
    strobes.clearCnt   = ctrlWr && wrData[BIT_CLEAR];
    strobes.latchLow   = rdEn && (addr == ADDR_HIGH);
    strobes.releaseLow = rdEn && (addr == ADDR_LOW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapSel <= '0;
      ienQ   <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        tapSel <= wrData[SEL_W-1:0];
        ienQ   <= wrData[BIT_IEN];
      end
      if (wrapPulse)                      flagQ <= 1'b1;
      else if (ctrlWr && wrData[BIT_FLAG]) flagQ <= 1'b0;
    end
  end

  assign irq = flagQ && ienQ;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL: begin
        rdData[SEL_W-1:0] = tapSel;
        rdData[BIT_FLAG]  = flagQ;
        rdData[BIT_IEN]   = ienQ;
      end
      ADDR_HIGH: rdData = cntQ[CNT_W-1:DATA_W];
      ADDR_LOW:  rdData = latchedQ ? bufQ : cntQ[DATA_W-1:0];
      default:   rdData = '0;
    endcase
  end

  // R9
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> irq == ienQ);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(ctrlWr && wrData[BIT_FLAG])) |=> flagQ);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int SEL_W = $clog2(DIV_W + 1);

  ctrlStrobes_t      strobes;
  logic [SEL_W-1:0]  tapSel;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] bufQ;
  logic              latchedQ;
  logic              wrapPulse;

  timer_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cntQ(cntQ), .bufQ(bufQ), .latchedQ(latchedQ),
    .wrapPulse(wrapPulse), .strobes(strobes), .tapSel(tapSel),
    .rdData(rdData), .irq(irq)
  );

  timer_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tapSel(tapSel),
    .cntQ(cntQ), .bufQ(bufQ), .latchedQ(latchedQ), .wrapPulse(wrapPulse)
  );
endmodule

// File: tb/prescaled_timer_test.sv
`timescale 1ns/1ps
module prescaled_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prescaled_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // reference state, built from the requirements
  logic [15:0] refCnt;
  logic [5:0]  refDiv;
  logic [2:0]  refSel;
  logic        refIen, refFlag, refLatched;
  logic [7:0]  refBuf;

  function automatic logic refTick(input logic [2:0] sel, input logic [5:0] dv);
    int s;
    int m;
    s = (sel == 3'd7) ? 6 : int'(sel);
    m = (1 << s) - 1;
    return (int'(dv) & m) == m;
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {3'b000, refIen, refFlag, refSel};
      2'd1: return refCnt[15:8];
      2'd2: return refLatched ? refBuf : refCnt[7:0];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0; refDiv <= '0; refSel <= '0;
      refIen <= 1'b0; refFlag <= 1'b0; refLatched <= 1'b0; refBuf <= '0;
    end else begin
      logic clr, tk, wrap;
      clr  = wrEn && addr == 2'd0 && wrData[5];
      tk   = refTick(refSel, refDiv);
      wrap = !clr && tk && refCnt == 16'hFFFF;
      if (clr) begin
        refCnt <= '0; refDiv <= '0;
      end else begin
        refDiv <= refDiv + 1'b1;
        if (tk) refCnt <= refCnt + 1'b1;
      end
      if (wrEn && addr == 2'd0) begin
        refSel <= wrData[2:0]; refIen <= wrData[4];
      end
      if (wrap) refFlag <= 1'b1;
      else if (wrEn && addr == 2'd0 && wrData[3]) refFlag <= 1'b0;
      if (rdEn && addr == 2'd2) refLatched <= 1'b0;
      else if (rdEn && addr == 2'd1 && !refLatched) begin
        refLatched <= 1'b1; refBuf <= refCnt[7:0];
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic op(input string tag, input logic w, input logic r,
                    input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    #1;
    if (r) check(tag, rdData, expRead(a));
    check("R9 irq", {7'd0, irq}, {7'd0, refFlag & refIen});
    @(posedge clk);
    #1;
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    op("R1 ctrl", 0, 1, 2'd0, 0);
    check("R1 ctrl zero", rdData, 8'h00);
    op("R1 high", 0, 1, 2'd1, 0);
    op("R1 low", 0, 1, 2'd2, 0);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 every tap rate, R8 clear and first-period
    for (int s = 0; s < 7; s++) begin
      op("R8 clear", 1, 0, 2'd0, 8'h20 | 8'(s));
      op("R8 count zero", 0, 1, 2'd2, 0);
      op("R8 clear bit reads 0", 0, 1, 2'd0, 0);
      idle(3 * (1 << s) + 1);
      op("R6 live low", 0, 1, 2'd2, 0);
      idle(1 << s);
      op("R2 rate", 0, 1, 2'd2, 0);
    end

    // R3 code 7 equals code 6
    op("R3 sel7", 1, 0, 2'd0, 8'h27);
    idle(200);
    op("R3 high", 0, 1, 2'd1, 0);
    op("R3 low", 0, 1, 2'd2, 0);

    // R4 R5 R10 coherent read
    op("R4 sel0", 1, 0, 2'd0, 8'h20);
    idle(37);
    op("R4 high", 0, 1, 2'd1, 0);
    idle(20);
    op("R5 repeat high", 0, 1, 2'd1, 0);
    op("R7 write high", 1, 0, 2'd1, 8'hA5);
    op("R7 write low", 1, 0, 2'd2, 8'h5A);
    op("R7 write spare", 1, 0, 2'd3, 8'hFF);
    idle(500);
    op("R10 held low", 0, 1, 2'd2, 0);
    op("R6 live after release", 0, 1, 2'd2, 0);
    op("R7 spare reads 0", 0, 1, 2'd3, 0);

    // R9 wrap, sticky flag, irq gating, clear by writing 1
    op("R9 setup", 1, 0, 2'd0, 8'h30);
    idle(65540);
    op("R9 flag set", 0, 1, 2'd0, 0);
    check("R9 irq high", {7'd0, irq}, 8'h01);
    op("R9 mask", 1, 0, 2'd0, 8'h00);
    op("R9 irq masked", 0, 1, 2'd0, 0);
    op("R9 w1c", 1, 0, 2'd0, 8'h18);
    op("R9 flag cleared", 0, 1, 2'd0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int kind;
      logic [1:0] a;
      logic [7:0] d;
      kind = int'($urandom_range(0, 9));
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom_range(0, 255));
      if (kind < 5) op("R4 R6 random read", 0, 1, a, 0);
      else if (kind < 6) op("R8 random ctrl", 1, 0, 2'd0, d);
      else if (kind < 7) op("R7 random write", 1, 0, a == 2'd0 ? 2'd1 : a, d);
      else if (kind < 8) op("R9 random ctrl keep", 1, 0, 2'd0, d & 8'hDF);
      else idle(int'($urandom_range(1, 40)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule